// File: doc/BRIEF.md
# Two-Section Decade Counter with Gated Clear and Preset

This block is a synchronous model of a split decade counter. A one-bit halving section drives output `q_a`, and a separate five-state section drives `q_b`, `q_c` and `q_d`. Each section has its own count input. A section advances when its count input goes from high to low. A system clock samples both count inputs through a short synchroniser, so every state change happens on `clk`.

When `q_a` is wired to the five-state section's count input, the outputs `{q_d,q_c,q_b,q_a}` step through the BCD digits 0 to 9. Two AND-gated control pairs act on both sections:
- The clear pair forces the digit to 0.
- The preset pair forces it to 9.

These pairs can be fed from the block's own outputs to shorten the cycle. For example, feeding `q_b` and `q_c` to the clear pair gives a count of six.

To build a two-digit counter, drive the upper digit's halving input from the lower digit's `q_d`. `carry_out` is a one-clock pulse that marks each fall of `q_d`.

The halving section is a two-state machine with states H_EVEN and H_ODD. Its transitions are:
- toggle (on a tick)
- force-even (on clear)
- force-odd (on preset)

The five-state section has states Q5_0 to Q5_4. Its transitions are:
- advance (Q5_n to Q5_n+1 on a tick)
- wrap (Q5_4 to Q5_0)
- clear (to Q5_0)
- preset (to Q5_4)

Top module: `decade_div_counter`

## Requirements
- R1: After `rst_n` is low, all of `q_a`, `q_b`, `q_c`, `q_d` and `carry_out` are 0.
- R2: A high-to-low change of `cnt_a_in` toggles `q_a`, visible on the third rising `clk` edge after the change. A high level, a low level or a rising change does not toggle it.
- R3: A high-to-low change of `cnt_b_in` advances `{q_d,q_c,q_b}` through 000, 001, 010, 011, 100 and then back to 000.
- R4: With `cnt_b_in` driven from `q_a`, successive falling changes of `cnt_a_in` produce the values 0,1,...,9,0 on `{q_d,q_c,q_b,q_a}` as a binary number.
- R5: When `clr_a` and `clr_b` are both high, the next rising `clk` edge forces all four outputs to 0. Either one high alone has no effect.
- R6: When `nine_a` and `nine_b` are both high (and the clear pair is not), the next rising `clk` edge forces `{q_d,q_c,q_b,q_a}` to 1001. Either one high alone has no effect.
- R7: If the clear pair and the preset pair are both fully asserted, the result is 0.
- R8: While the clear pair or the preset pair is held, count-input falls are ignored and the outputs stay at the forced value.
- R9: If `cnt_b_in` never falls, `q_b`, `q_c` and `q_d` keep their values while `q_a` toggles.
- R10: `carry_out` is high for exactly one clock, two rising edges after `q_d` falls from 1 to 0, and is low otherwise.
- R11: With `q_b` and `q_c` fed to the clear pair (and `cnt_b_in` from `q_a`), the settled count after n falls is n mod 6. State 6 lasts one clock only.
- R12: Two instances, with the upper `cnt_a_in` driven by the lower `q_d`, settle to a value of upper*10+lower that equals n mod 100 after n falls of the lower `cnt_a_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_in | input | 1 | Count input of the halving section (falling change counts) |
| cnt_b_in | input | 1 | Count input of the five-state section (falling change counts) |
| clr_a | input | 1 | Clear-pair input 1 |
| clr_b | input | 1 | Clear-pair input 2 |
| nine_a | input | 1 | Preset-to-nine pair input 1 |
| nine_b | input | 1 | Preset-to-nine pair input 2 |
| q_a | output | 1 | Halving section output, digit weight 1 |
| q_b | output | 1 | Five-state section output, weight 2 |
| q_c | output | 1 | Five-state section output, weight 4 |
| q_d | output | 1 | Five-state section output, weight 8 |
| carry_out | output | 1 | One-clock pulse after each fall of `q_d` |

## Verification
The digit is tried with several count-input wirings, each of which isolates a different fault:
- Chained halving and five-state sections: a complete 0–9–0 sweep catches wrong state order or a wrong wrap.
- Five-state input held still: exposes any leak of counting into `q_b`..`q_d`.
- Self-clearing mod-6 loop: checks that the gated clear acts within one clock.
- Two-digit cascade swept over all 100 values and back to 00: catches carry faults that appear only at the 9-to-0 boundary.

Single-line, paired, held and conflicting clear/preset patterns separate the AND gating, the override and the priority.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
    typedef enum logic {
        H_EVEN = 1'b0,
        H_ODD  = 1'b1
    } half_e;

    typedef enum logic [2:0] {
        Q5_0 = 3'd0,
        Q5_1 = 3'd1,
        Q5_2 = 3'd2,
        Q5_3 = 3'd3,
        Q5_4 = 3'd4
    } quint_e;
endpackage

// File: rtl/dcnt_fall_sync.sv
module dcnt_fall_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic tick
);
    localparam int LAST = STAGES;

    logic [LAST:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[LAST-1:0], din};
    end

    always_comb tick = pipe[LAST] & ~pipe[LAST-1];

    // R2: a detected fall lasts one clock only
    p_single_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dcnt_half.sv
module dcnt_half
    import dcnt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic force_zero,
    input  logic force_nine,
    output logic q
);
    half_e st, nxt;

    always_comb begin
        nxt = st;
        if (force_zero)      nxt = H_EVEN;
        else if (force_nine) nxt = H_ODD;
        else if (tick) begin
            unique case (st)
                H_EVEN: nxt = H_ODD;
                H_ODD:  nxt = H_EVEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= H_EVEN;
        else        st <= nxt;
    end

    always_comb begin
        unique case (st)
            H_EVEN: q = 1'b0;
            H_ODD:  q = 1'b1;
        endcase
    end

    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !force_zero && !force_nine) |=> (q != $past(q)));
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |=> !q);
endmodule

// File: rtl/dcnt_quint.sv
module dcnt_quint
    import dcnt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       force_zero,
    input  logic       force_nine,
    output logic [2:0] dcb
);
    quint_e st, nxt;

    always_comb begin
        nxt = st;
        if (force_zero)      nxt = Q5_0;
        else if (force_nine) nxt = Q5_4;
        else if (tick) begin
            unique case (st)
                Q5_0:    nxt = Q5_1;
                Q5_1:    nxt = Q5_2;
                Q5_2:    nxt = Q5_3;
                Q5_3:    nxt = Q5_4;
                Q5_4:    nxt = Q5_0;
                default: nxt = Q5_0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= Q5_0;
        else        st <= nxt;
    end

    always_comb begin
        unique case (st)
            Q5_0:    dcb = 3'b000;
            Q5_1:    dcb = 3'b001;
            Q5_2:    dcb = 3'b010;
            Q5_3:    dcb = 3'b011;
            Q5_4:    dcb = 3'b100;
            default: dcb = 3'b000;
        endcase
    end

    p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !force_zero && !force_nine && dcb == 3'b100) |=> (dcb == 3'b000));
    p_prio_r7: assert property (@(posedge clk) disable iff (!rst_n)
        force_zero |=> (dcb == 3'b000));
    p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_nine && !force_zero) |=> (dcb == 3'b100));
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !force_zero && !force_nine) |=> $stable(dcb));
endmodule

// File: rtl/decade_div_counter.sv
module decade_div_counter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cnt_a_in,
    input  logic cnt_b_in,
    input  logic clr_a,
    input  logic clr_b,
    input  logic nine_a,
    input  logic nine_b,
    output logic q_a,
    output logic q_b,
    output logic q_c,
    output logic q_d,
    output logic carry_out
);
    logic tick_a, tick_b;
    logic force_zero, force_nine;
    logic [2:0] dcb;
    logic d_prev, carry_q;

    always_comb force_zero = clr_a & clr_b;
    always_comb force_nine = nine_a & nine_b;

    dcnt_fall_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .din(cnt_a_in), .tick(tick_a));
    dcnt_fall_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .din(cnt_b_in), .tick(tick_b));

    dcnt_half u_half (
        .clk(clk), .rst_n(rst_n), .tick(tick_a),
        .force_zero(force_zero), .force_nine(force_nine), .q(q_a));

    dcnt_quint u_quint (
        .clk(clk), .rst_n(rst_n), .tick(tick_b),
        .force_zero(force_zero), .force_nine(force_nine), .dcb(dcb));

    always_comb begin
        q_b = dcb[0];
        q_c = dcb[1];
        q_d = dcb[2];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            d_prev  <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            d_prev  <= q_d;
            carry_q <= d_prev & ~q_d;
        end
    end

    always_comb carry_out = carry_q;

    p_carry_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> (!$past(q_d) && $past(q_d, 2)));
    p_carry_width_r10: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |=> !carry_out);
    p_preset_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_nine && !force_zero) |=> ({q_d, q_c, q_b, q_a} == 4'b1001));
endmodule

// File: tb/decade_div_counter_test.sv
module decade_div_counter_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ca = 1'b0, ext_b = 1'b0, link = 1'b0, mod6 = 1'b0;
    logic z0 = 1'b0, z1 = 1'b0, n0 = 1'b0, n1 = 1'b0;
    logic lo_a, lo_b, lo_c, lo_d, lo_cy;
    logic hi_a, hi_b, hi_c, hi_d, hi_cy;
    logic lo_cb, lo_c0, lo_c1;
    int total = 0, bad = 0, carries = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assign lo_cb = link ? lo_a : ext_b;
    assign lo_c0 = mod6 ? lo_b : z0;
    assign lo_c1 = mod6 ? lo_c : z1;

    decade_div_counter uut (
        .clk(clk), .rst_n(rst_n), .cnt_a_in(ca), .cnt_b_in(lo_cb),
        .clr_a(lo_c0), .clr_b(lo_c1), .nine_a(n0), .nine_b(n1),
        .q_a(lo_a), .q_b(lo_b), .q_c(lo_c), .q_d(lo_d), .carry_out(lo_cy));

    decade_div_counter hi (
        .clk(clk), .rst_n(rst_n), .cnt_a_in(lo_d), .cnt_b_in(hi_a),
        .clr_a(1'b0), .clr_b(1'b0), .nine_a(1'b0), .nine_b(1'b0),
        .q_a(hi_a), .q_b(hi_b), .q_c(hi_c), .q_d(hi_d), .carry_out(hi_cy));

    always @(posedge clk) if (lo_cy) carries <= carries + 1;

    function automatic int lo_val();
        return {lo_d, lo_c, lo_b, lo_a};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse();
        @(negedge clk); ca = 1'b1; clocks(16);
        ca = 1'b0; clocks(16);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; ca = 1'b0; ext_b = 1'b0;
        clocks(3); rst_n = 1'b1; clocks(2);
    endtask

    initial begin
        clocks(2);
        // R1 reset state
        check("R1 outputs", lo_val(), 0);
        check("R1 carry", int'(lo_cy), 0);
        rst_n = 1'b1; clocks(2);

        // R2 exact latency: fall driven at negedge, seen after third rising edge
        ca = 1'b1; clocks(6);
        check("R2 rise no toggle", int'(lo_a), 0);
        ca = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        check("R2 not yet", int'(lo_a), 0);
        @(posedge clk); #1;
        check("R2 toggle at 3rd edge", int'(lo_a), 1);
        clocks(6);
        check("R2 low level holds", int'(lo_a), 1);

        // R3 five-state section driven alone
        do_reset();
        for (int k = 1; k <= 6; k++) begin
            @(negedge clk); ext_b = 1'b1; clocks(8); ext_b = 1'b0; clocks(8);
            check("R3 dcb", {lo_d, lo_c, lo_b}, k % 5);
        end

        // R4 chained 0..9 and wrap, R10 carry count
        do_reset(); link = 1'b1; carries = 0;
        for (int k = 1; k <= 10; k++) begin
            pulse();
            check("R4 digit", lo_val(), k % 10);
        end
        check("R10 one carry per wrap", carries, 1);

        // R5 clear pair gating
        for (int k = 0; k < 3; k++) pulse();
        @(negedge clk); z0 = 1'b1; clocks(3);
        check("R5 single clear ignored", lo_val(), 3);
        z0 = 1'b0; z1 = 1'b1; clocks(3);
        check("R5 single clear ignored b", lo_val(), 3);
        z0 = 1'b1; @(posedge clk); #1;
        check("R5 clear next edge", lo_val(), 0);
        // R8 held clear overrides counting
        pulse(); pulse();
        check("R8 held clear", lo_val(), 0);
        @(negedge clk); z0 = 1'b0; z1 = 1'b0; clocks(2);

        // R6 preset pair gating
        pulse(); pulse();
        @(negedge clk); n0 = 1'b1; clocks(3);
        check("R6 single preset ignored", lo_val(), 2);
        n0 = 1'b0; n1 = 1'b1; clocks(3);
        check("R6 single preset ignored b", lo_val(), 2);
        n0 = 1'b1; @(posedge clk); #1;
        check("R6 preset next edge", lo_val(), 9);
        pulse();
        check("R8 held preset", lo_val(), 9);
        // R7 both pairs: clear wins
        @(negedge clk); z0 = 1'b1; z1 = 1'b1; clocks(2);
        check("R7 clear over preset", lo_val(), 0);
        @(negedge clk); z0 = 1'b0; z1 = 1'b0; n0 = 1'b0; n1 = 1'b0; clocks(2);

        // R9 five-state input not driven: only A toggles, from preset nine
        link = 1'b0; ext_b = 1'b0;
        @(negedge clk); n0 = 1'b1; n1 = 1'b1; clocks(2); n0 = 1'b0; n1 = 1'b0;
        for (int k = 1; k <= 4; k++) begin
            pulse();
            check("R9 dcb frozen", {lo_d, lo_c, lo_b}, 4);
            check("R9 a toggles", int'(lo_a), (k % 2 == 0) ? 1 : 0);
        end

        // R11 mod-6 feedback
        do_reset(); link = 1'b1; mod6 = 1'b1;
        for (int k = 1; k <= 13; k++) begin
            pulse();
            check("R11 mod6", lo_val(), k % 6);
        end
        mod6 = 1'b0;

        // R12 two-digit cascade 00..99..00
        do_reset(); link = 1'b1;
        check("R12 start", {hi_d, hi_c, hi_b, hi_a} * 10 + lo_val(), 0);
        for (int k = 1; k <= 100; k++) begin
            pulse();
            check("R12 cascade", int'({hi_d, hi_c, hi_b, hi_a}) * 10 + lo_val(), k % 100);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule